// File: doc/BRIEF.md
# DRAM Row, Column and Bank Mapper

This block converts a rank-relative address into the coordinates a DRAM device understands: a row number, a column number, a two-bit bank address and a two-bit bank group. It sits between the rank decode and the command scheduler of a memory controller, or in an error-reporting path that must name the failing location. The address bits that form each field are not contiguous. They are picked from fixed, irregular position lists, and the list used depends on whether the channel runs in close-page or open-page policy and, for open page, whether fine-grain bank spreading is enabled.

Both bank fields can be hashed. When hashing is enabled, a second pair of higher address bits is XORed into the primary pair, which spreads consecutive rows across banks. The configured row and column widths limit how many list entries are gathered. In close-page policy, column bit 10 is always set so that every access carries auto-precharge.

The mapper registers its result once. A request presented with `in_valid` high in one cycle appears on the outputs in the next cycle, marked by `out_valid`. The outputs hold their last value while no request arrives.

Top module: `dram_loc_mapper`

## Requirements
- R1: A request with `in_valid` high at a rising edge produces `out_valid` high after exactly that edge. `out_valid` is low after any edge where `in_valid` was low.
- R2: While `rst_n` is low, all outputs read zero.
- R3: In close-page mode (`close_page`=1), row bit i is taken from rank-address bit 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33 for i = 0..16.
- R4: In close-page mode, column bits 0..9 are taken from address bits 3,4,5,14,19,23,24,25,26,27, and column bit 10 is always 1.
- R5: In open-page mode (`close_page`=0), row bit i is taken from address bit 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33 for i = 0..16.
- R6: In open-page mode, column bits 0..9 come from address bits 3..12 when `fine_bank`=0, and from bits 3,4,5,7,8,9,10,11,12,13 when `fine_bank`=1. Column bit 10 is 0.
- R7: In close-page mode, bank_addr = {a[9],a[8]} XOR {a[28],a[22]} and bank_grp = {a[7],a[6]} XOR {a[21],a[20]}. The XOR term applies only when `bank_xor_en`=1.
- R8: In open-page mode, bank_addr = {a[19],a[18]} XOR {a[23],a[22]}. bank_grp = {a[17], a[13] (normal) or a[6] (fine)} XOR {a[21],a[20]}. The XOR term applies only when `bank_xor_en`=1.
- R9: With `bank_xor_en`=0, each bank field equals its primary bit pair alone.
- R10: Only row bits below `row_bits` and column bits below `col_bits` are gathered. The bits above these counts read 0, except column bit 10.
- R11: A `row_bits` value above 17 acts as 17, and a `col_bits` value above 10 acts as 10.
- R12: While `in_valid` is low, row, column and bank outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| rank_addr | input | 34 | Rank-relative address |
| close_page | input | 1 | 1 = close-page policy, 0 = open-page policy |
| fine_bank | input | 1 | Fine-grain bank layout, used in open-page mode |
| bank_xor_en | input | 1 | Enables XOR hashing of both bank fields |
| row_bits | input | 5 | Number of row bits to gather |
| col_bits | input | 4 | Number of column bits to gather |
| out_valid | output | 1 | Registered result is valid |
| row | output | 17 | DRAM row |
| col | output | 11 | DRAM column, with bit 10 as the auto-precharge flag |
| bank_addr | output | 2 | Bank address within the group |
| bank_grp | output | 2 | Bank group |

## Verification
The assertions run on every cycle and check the following properties:
- the one-cycle valid latency;
- clearing of the outputs under reset;
- the auto-precharge bit, set for close page and clear for open page;
- masking of row bits above the configured count;
- the unhashed close-page bank address;
- holding of all outputs while no request arrives.

The exact gather order of each position list, the hashed bank values, the fine-grain selections and the clamping of oversized counts can only be shown by the bench. It drives chosen addresses and compares every field against values worked out from the position lists.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
    localparam int ADDR_W   = 34;
    localparam int ROW_MAX  = 17;
    localparam int COL_MAX  = 10;
    localparam int AP_BIT   = 10;
    localparam int COL_W    = AP_BIT + 1;
    localparam int POS_W    = 6;
    localparam int ROW_CW   = $clog2(ROW_MAX + 1);
    localparam int COL_CW   = $clog2(COL_MAX + 1);

    // Position lists, entry 0 in the least significant slot.
    localparam logic [ROW_MAX*POS_W-1:0] ROW_CLOSE_POS = {
        6'd33, 6'd32, 6'd31, 6'd30, 6'd29, 6'd13, 6'd12, 6'd11, 6'd10,
        6'd28, 6'd22, 6'd21, 6'd20, 6'd18, 6'd17, 6'd16, 6'd15};
    localparam logic [ROW_MAX*POS_W-1:0] ROW_OPEN_POS = {
        6'd33, 6'd32, 6'd31, 6'd30, 6'd29, 6'd27, 6'd26, 6'd25, 6'd24,
        6'd23, 6'd22, 6'd21, 6'd28, 6'd20, 6'd16, 6'd15, 6'd14};
    localparam logic [COL_MAX*POS_W-1:0] COL_CLOSE_POS = {
        6'd27, 6'd26, 6'd25, 6'd24, 6'd23, 6'd19, 6'd14, 6'd5, 6'd4, 6'd3};
    localparam logic [COL_MAX*POS_W-1:0] COL_OPEN_POS = {
        6'd12, 6'd11, 6'd10, 6'd9, 6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3};
    localparam logic [COL_MAX*POS_W-1:0] COL_FINE_POS = {
        6'd13, 6'd12, 6'd11, 6'd10, 6'd9, 6'd8, 6'd7, 6'd5, 6'd4, 6'd3};

    typedef enum logic [1:0] {
        COL_SEL_CLOSE = 2'd0,
        COL_SEL_OPEN  = 2'd1,
        COL_SEL_FINE  = 2'd2
    } col_sel_e;
endpackage

// File: rtl/dmap_gather.sv
module dmap_gather #(
    parameter int ADDR_W = 34,
    parameter int N      = 17,
    parameter int CNT_W  = 5,
    parameter int POS_W  = 6,
    parameter logic [N*POS_W-1:0] POS = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic [N-1:0]      field
);
    localparam logic [CNT_W-1:0] N_CNT = CNT_W'(N);

    logic [CNT_W-1:0] eff_cnt;
    assign eff_cnt = (count > N_CNT) ? N_CNT : count;

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int SRC = int'(POS[i*POS_W +: POS_W]);
        assign field[i] = (CNT_W'(i) < eff_cnt) ? addr[SRC] : 1'b0;
    end
endmodule

// File: rtl/dmap_bank_hash.sv
module dmap_bank_hash #(
    parameter int ADDR_W = 34,
    parameter int B0 = 0,
    parameter int B1 = 1,
    parameter int X0 = 2,
    parameter int X1 = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              xor_en,
    output logic [1:0]        bits
);
    logic [1:0] base_pair;
    logic [1:0] hash_pair;
    assign base_pair = {addr[B1], addr[B0]};
    assign hash_pair = xor_en ? {addr[X1], addr[X0]} : 2'b00;
    assign bits = base_pair ^ hash_pair;
endmodule

// File: rtl/dram_loc_mapper.sv
module dram_loc_mapper
    import dmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   rank_addr,
    input  logic                close_page,
    input  logic                fine_bank,
    input  logic                bank_xor_en,
    input  logic [ROW_CW-1:0]   row_bits,
    input  logic [COL_CW-1:0]   col_bits,
    output logic                out_valid,
    output logic [ROW_MAX-1:0]  row,
    output logic [COL_W-1:0]    col,
    output logic [1:0]          bank_addr,
    output logic [1:0]          bank_grp
);
    logic [ROW_MAX-1:0] row_close, row_open;
    logic [COL_MAX-1:0] col_close, col_open, col_fine;
    logic [1:0] ba_close, bg_close, ba_open, bg_open_norm, bg_open_fine;

    logic [ROW_MAX-1:0] row_nxt;
    logic [COL_W-1:0]   col_nxt;
    logic [1:0]         ba_nxt, bg_nxt;
    col_sel_e           col_sel;

    dmap_gather #(.ADDR_W(ADDR_W), .N(ROW_MAX), .CNT_W(ROW_CW), .POS_W(POS_W),
                  .POS(ROW_CLOSE_POS)) u_row_close (
        .addr(rank_addr), .count(row_bits), .field(row_close));
    dmap_gather #(.ADDR_W(ADDR_W), .N(ROW_MAX), .CNT_W(ROW_CW), .POS_W(POS_W),
                  .POS(ROW_OPEN_POS)) u_row_open (
        .addr(rank_addr), .count(row_bits), .field(row_open));
    dmap_gather #(.ADDR_W(ADDR_W), .N(COL_MAX), .CNT_W(COL_CW), .POS_W(POS_W),
                  .POS(COL_CLOSE_POS)) u_col_close (
        .addr(rank_addr), .count(col_bits), .field(col_close));
    dmap_gather #(.ADDR_W(ADDR_W), .N(COL_MAX), .CNT_W(COL_CW), .POS_W(POS_W),
                  .POS(COL_OPEN_POS)) u_col_open (
        .addr(rank_addr), .count(col_bits), .field(col_open));
    dmap_gather #(.ADDR_W(ADDR_W), .N(COL_MAX), .CNT_W(COL_CW), .POS_W(POS_W),
                  .POS(COL_FINE_POS)) u_col_fine (
        .addr(rank_addr), .count(col_bits), .field(col_fine));

    dmap_bank_hash #(.ADDR_W(ADDR_W), .B0(8),  .B1(9),  .X0(22), .X1(28)) u_ba_close (
        .addr(rank_addr), .xor_en(bank_xor_en), .bits(ba_close));
    dmap_bank_hash #(.ADDR_W(ADDR_W), .B0(6),  .B1(7),  .X0(20), .X1(21)) u_bg_close (
        .addr(rank_addr), .xor_en(bank_xor_en), .bits(bg_close));
    dmap_bank_hash #(.ADDR_W(ADDR_W), .B0(18), .B1(19), .X0(22), .X1(23)) u_ba_open (
        .addr(rank_addr), .xor_en(bank_xor_en), .bits(ba_open));
    dmap_bank_hash #(.ADDR_W(ADDR_W), .B0(13), .B1(17), .X0(20), .X1(21)) u_bg_open_n (
        .addr(rank_addr), .xor_en(bank_xor_en), .bits(bg_open_norm));
    dmap_bank_hash #(.ADDR_W(ADDR_W), .B0(6),  .B1(17), .X0(20), .X1(21)) u_bg_open_f (
        .addr(rank_addr), .xor_en(bank_xor_en), .bits(bg_open_fine));

    always_comb begin
        if (close_page)     col_sel = COL_SEL_CLOSE;
        else if (fine_bank) col_sel = COL_SEL_FINE;
        else                col_sel = COL_SEL_OPEN;
    end

    always_comb begin
        col_nxt = '0;
        unique case (col_sel)
            COL_SEL_CLOSE: begin
                col_nxt[COL_MAX-1:0] = col_close;
                col_nxt[AP_BIT]      = 1'b1;
                bg_nxt               = bg_close;
            end
            COL_SEL_FINE: begin
                col_nxt[COL_MAX-1:0] = col_fine;
                bg_nxt               = bg_open_fine;
            end
            default: begin
                col_nxt[COL_MAX-1:0] = col_open;
                bg_nxt               = bg_open_norm;
            end
        endcase
        row_nxt = close_page ? row_close : row_open;
        ba_nxt  = close_page ? ba_close  : ba_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            row       <= '0;
            col       <= '0;
            bank_addr <= '0;
            bank_grp  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                row       <= row_nxt;
                col       <= col_nxt;
                bank_addr <= ba_nxt;
                bank_grp  <= bg_nxt;
            end
        end
    end
endmodule

// File: rtl/dram_loc_mapper_chk.sv
module dram_loc_mapper_chk
    import dmap_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [ADDR_W-1:0]   rank_addr,
    input logic                close_page,
    input logic                bank_xor_en,
    input logic [ROW_CW-1:0]   row_bits,
    input logic                out_valid,
    input logic [ROW_MAX-1:0]  row,
    input logic [COL_W-1:0]    col,
    input logic [1:0]          bank_addr,
    input logic [1:0]          bank_grp
);
    p_valid_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && row == '0 && col == '0 && bank_addr == '0 && bank_grp == '0));
    p_ap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && close_page) |=> col[AP_BIT]);
    p_ap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !close_page) |=> !col[AP_BIT]);
    p_row_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && row_bits < ROW_CW'(ROW_MAX)) |=> ((row >> $past(row_bits)) == '0));
    p_plain_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && close_page && !bank_xor_en) |=>
            (bank_addr == $past({rank_addr[9], rank_addr[8]})));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(row) && $stable(col) && $stable(bank_addr) && $stable(bank_grp)));
endmodule

bind dram_loc_mapper dram_loc_mapper_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rank_addr(rank_addr),
    .close_page(close_page), .bank_xor_en(bank_xor_en), .row_bits(row_bits),
    .out_valid(out_valid), .row(row), .col(col),
    .bank_addr(bank_addr), .bank_grp(bank_grp));

// File: tb/dram_loc_mapper_tb_top.sv
`timescale 1ns/1ps
module dram_loc_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [33:0] rank_addr = '0;
    logic        close_page = 1'b0, fine_bank = 1'b0, bank_xor_en = 1'b0;
    logic [4:0]  row_bits = '0;
    logic [3:0]  col_bits = '0;
    logic        out_valid;
    logic [16:0] row;
    logic [10:0] col;
    logic [1:0]  bank_addr, bank_grp;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dram_loc_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rank_addr(rank_addr),
        .close_page(close_page), .fine_bank(fine_bank), .bank_xor_en(bank_xor_en),
        .row_bits(row_bits), .col_bits(col_bits), .out_valid(out_valid),
        .row(row), .col(col), .bank_addr(bank_addr), .bank_grp(bank_grp));

    typedef struct packed {
        logic [33:0] addr;
        logic        cp;
        logic        fb;
        logic        xe;
        logic [4:0]  rb;
        logic [3:0]  cb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{34'h3_5A5A_5A5A, 1'b1, 1'b0, 1'b0, 5'd17, 4'd10},
        '{34'h3_5A5A_5A5A, 1'b1, 1'b0, 1'b1, 5'd17, 4'd10},
        '{34'h1_F0F0_0F0F, 1'b0, 1'b0, 1'b0, 5'd17, 4'd10},
        '{34'h1_F0F0_0F0F, 1'b0, 1'b1, 1'b1, 5'd17, 4'd10},
        '{34'h2_C3C3_3C3C, 1'b0, 1'b0, 1'b1, 5'd15, 4'd10},
        '{34'h2_C3C3_3C3C, 1'b1, 1'b0, 1'b1, 5'd14, 4'd8},
        '{34'h3_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 5'd16, 4'd10},
        '{34'h3_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 5'd12, 4'd9},
        '{34'h0_8421_1248, 1'b0, 1'b0, 1'b1, 5'd31, 4'd15},
        '{34'h0_8421_1248, 1'b1, 1'b0, 1'b1, 5'd20, 4'd12}
    };

    localparam int CR [17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
    localparam int OR [17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
    localparam int CC [10] = '{3,4,5,14,19,23,24,25,26,27};
    localparam int OC [10] = '{3,4,5,6,7,8,9,10,11,12};
    localparam int FC [10] = '{3,4,5,7,8,9,10,11,12,13};

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int pair(input logic [33:0] a, input int p0, input int p1);
        return int'({a[p1], a[p0]});
    endfunction

    task automatic model(input vec_t v, output int r, output int c, output int ba, output int bg);
        int nr = (int'(v.rb) > 17) ? 17 : int'(v.rb);
        int nc = (int'(v.cb) > 10) ? 10 : int'(v.cb);
        r = 0; c = 0;
        for (int i = 0; i < nr; i++)
            r |= int'(v.addr[v.cp ? CR[i] : OR[i]]) << i;
        for (int i = 0; i < nc; i++)
            c |= int'(v.addr[v.cp ? CC[i] : (v.fb ? FC[i] : OC[i])]) << i;
        if (v.cp) begin
            c |= 1 << 10;
            ba = pair(v.addr, 8, 9)  ^ (v.xe ? pair(v.addr, 22, 28) : 0);
            bg = pair(v.addr, 6, 7)  ^ (v.xe ? pair(v.addr, 20, 21) : 0);
        end else begin
            ba = pair(v.addr, 18, 19) ^ (v.xe ? pair(v.addr, 22, 23) : 0);
            bg = pair(v.addr, v.fb ? 6 : 13, 17) ^ (v.xe ? pair(v.addr, 20, 21) : 0);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        rank_addr = v.addr; close_page = v.cp; fine_bank = v.fb;
        bank_xor_en = v.xe; row_bits = v.rb; col_bits = v.cb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        int er, ec, eba, ebg;
        model(v, er, ec, eba, ebg);
        apply(v);
        chk("R1", "out_valid", int'(out_valid), 1);
        chk(req, "row", int'(row), er);
        chk(req, "col", int'(col), ec);
        chk(req, "bank_addr", int'(bank_addr), eba);
        chk(req, "bank_grp", int'(bank_grp), ebg);
    endtask

    task automatic direct(input vec_t v, input string req, input int er, input int ec,
                          input int eba, input int ebg);
        apply(v);
        chk(req, "row", int'(row), er);
        chk(req, "col", int'(col), ec);
        chk(req, "bank_addr", int'(bank_addr), eba);
        chk(req, "bank_grp", int'(bank_grp), ebg);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2", "out_valid", int'(out_valid), 0);
        chk("R2", "row", int'(row), 0);
        chk("R2", "col", int'(col), 0);
        rst_n = 1'b1;

        // Vector table: R3..R8 under several patterns, with counts and clamps (R10, R11)
        for (int k = 0; k < NV; k++)
            run_vec(VEC[k], "R3_R4_R5_R6_R7_R8_R10_R11");

        // R1: the edge after an idle cycle drops out_valid
        @(negedge clk);
        chk("R1", "out_valid idle", int'(out_valid), 0);

        // R3 R9: only bit 28 set, close page, no hash -> row bit 7, column 0x400
        direct('{34'h0_1000_0000, 1'b1, 1'b0, 1'b0, 5'd17, 4'd10}, "R3_R9", 32'h80, 32'h400, 0, 0);
        // R7: same address hashed -> bank_addr high bit from bit 28
        direct('{34'h0_1000_0000, 1'b1, 1'b0, 1'b1, 5'd17, 4'd10}, "R7", 32'h80, 32'h400, 2, 0);
        // R5: open page, bit 28 -> row bit 4
        direct('{34'h0_1000_0000, 1'b0, 1'b0, 1'b0, 5'd17, 4'd10}, "R5", 32'h10, 0, 0, 0);
        // R10: row count 4 masks bit 7
        direct('{34'h0_1000_0000, 1'b1, 1'b0, 1'b0, 5'd4, 4'd10}, "R10", 0, 32'h400, 0, 0);
        // R6 R8: bit 13 -> fine column bit 9; normal mode bank group bit 0
        direct('{34'h0_0000_2000, 1'b0, 1'b1, 1'b0, 5'd17, 4'd10}, "R6_R8", 0, 32'h200, 0, 0);
        direct('{34'h0_0000_2000, 1'b0, 1'b0, 1'b0, 5'd17, 4'd10}, "R6_R8", 0, 0, 0, 1);
        // R8: bit 6 feeds the group only in fine mode
        direct('{34'h0_0000_0040, 1'b0, 1'b1, 1'b0, 5'd17, 4'd10}, "R8", 0, 0, 0, 1);
        // R4 R11: col count 15 acts as 10, bit 27 -> column bit 9
        direct('{34'h0_0800_0000, 1'b1, 1'b0, 1'b0, 5'd31, 4'd15}, "R4_R11", 0, 32'h600, 0, 0);

        // R12: new inputs without in_valid leave outputs unchanged
        @(negedge clk);
        rank_addr = 34'h3_FFFF_FFFF; close_page = 1'b0; row_bits = 5'd17; col_bits = 4'd10;
        repeat (2) @(negedge clk);
        chk("R12", "row held", int'(row), 32'h0);
        chk("R12", "col held", int'(col), 32'h600);
        chk("R12", "bank_grp held", int'(bank_grp), 0);

        // R2: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2", "col after reset", int'(col), 0);
        chk("R2", "out_valid after reset", int'(out_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule